// File: doc/BRIEF.md
# Serial Transmit Engine with Fractional Bit Timing

This block turns bytes into asynchronous serial frames on a single output line. A producer hands it bytes over a valid/ready stream, and a one-deep holding register lets the next byte wait while the current frame is on the wire. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two high stop bits. The line rests high between frames.

The frame shape comes from a packed line-control word. The bit time comes from a 16-bit integer divisor and a 3-bit fractional value. The block runs on the reference clock itself. Each bit period is divided into 16 sub-bit ticks, and the fractional value lengthens the first few of those ticks by one clock each, so one bit lasts exactly 16 × divisor + fraction + 16 clocks. The engine samples the line-control word and the divisor settings when a frame starts, so changing them mid-frame does not disturb the frame already being sent.

Stream rules: `in_ready` is high when the holding register is empty. It is also high in the cycle the held byte moves into the shifter. A byte transfers on any rising edge where both `in_valid` and `in_ready` are high. A producer may hold `in_valid` high for as long as it needs, and the byte stays waiting until `in_ready` rises.

Top module: `uart_tx_frac`

## Requirements
- R1: The line idles at 1. A frame begins with one 0 start bit, followed by line_ctrl[1:0]+5 data bits, least significant bit first.
- R2: When line_ctrl[5] is 1, a parity bit follows the data bits. With line_ctrl[3]=1 it makes the count of ones in data plus parity even; with line_ctrl[3]=0 it makes that count odd. When line_ctrl[5] is 0, no parity bit is sent.
- R3: The frame ends with one stop bit at 1 when line_ctrl[2] is 0, and two stop bits when line_ctrl[2] is 1.
- R4: Every bit of the frame, including start, parity and stop bits, lasts exactly 16*baud_int + baud_frac + 16 clock cycles.
- R5: While baud_int is 0, no frame starts. An accepted byte stays held and txd stays high. The held byte starts its frame once baud_int becomes nonzero.
- R6: in_ready is 1 when the holding register is empty, or when the held byte moves to the shifter in that same cycle. While the held byte is kept, in_ready is 0.
- R7: When a byte is waiting as the last stop bit ends, its start bit follows in the very next cycle, with no idle gap.
- R8: busy is 1 exactly while a frame is being sent. tx_empty is 1 only when no frame is being sent and no byte is held.
- R9: line_ctrl[6] has no effect on the frame.
- R10: line_ctrl, baud_int and baud_frac are taken when a frame starts. Changing them during a frame does not affect that frame.
- R11: After reset, txd=1, busy=0, tx_empty=1 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all bit timing counts its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte offered for transmission |
| in_valid | input | 1 | in_data holds a byte to send |
| in_ready | output | 1 | The block accepts a byte this cycle |
| line_ctrl | input | 8 | Frame format: [1:0] data length, [2] stop count, [3] even parity, [5] parity enable, [6] no effect |
| baud_int | input | 16 | Integer bit-time divisor; 0 means not configured |
| baud_frac | input | 3 | Extra clocks added to each bit period |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is in progress |
| tx_empty | output | 1 | No frame in progress and no byte held |

## Verification
Two events can fall on the same clock edge: the end of the last stop bit loading the held byte into the shifter, and a new byte entering the holding register it just freed. The test causes this by queuing three bytes while the first frame is running. The third producer keeps in_valid high, so its byte can only be accepted in the hand-over cycle. Every clock of the three frames is compared with the expected waveform. The second and third start bits must follow directly after the stop bits, and the third byte's data must arrive intact.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [3:0] nbits;     // 5..8 data bits
    logic       par_en;
    logic       par_even;
    logic       two_stop;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_lc(input logic [7:0] lc);
    frame_cfg_t c;
    c.nbits    = 4'd5 + {2'b00, lc[1:0]};
    c.two_stop = lc[2];
    c.par_even = lc[3];
    c.par_en   = lc[5];
    return c;
  endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              bit_end
);
  localparam int CNT_W = DIV_W + 2;
  localparam int IDX_W = $clog2(OSR);

  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  logic [CNT_W-1:0]  sub_cnt;
  logic [IDX_W-1:0]  tick_idx;
  logic [CNT_W-1:0]  tick_len;
  logic              stretch;
  logic              sub_end;

  // The first frac_q ticks of each bit are one clock longer.
  assign stretch  = 32'(tick_idx) < 32'(frac_q);
  assign tick_len = CNT_W'(div_q) + CNT_W'(1) + CNT_W'(stretch);
  assign sub_end  = (sub_cnt == tick_len - CNT_W'(1));
  assign bit_end  = run && sub_end && (tick_idx == IDX_W'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      frac_q   <= '0;
      sub_cnt  <= '0;
      tick_idx <= '0;
    end else if (start) begin
      div_q    <= div_in;
      frac_q   <= frac_in;
      sub_cnt  <= '0;
      tick_idx <= '0;
    end else if (run) begin
      if (sub_end) begin
        sub_cnt  <= '0;
        tick_idx <= (tick_idx == IDX_W'(OSR - 1)) ? '0 : tick_idx + 1'b1;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end else begin
      sub_cnt  <= '0;
      tick_idx <= '0;
    end
  end

  p_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && !start && !sub_end |=> $stable(tick_idx));

  p_end_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> !bit_end);

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic accept;

  assign in_ready = !full || take;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= (full && !take) || accept;
      if (accept) data <= in_data;
    end
  end

  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && !take |=> full && $stable(data));

  p_take_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_full,
  input  logic [7:0]       hold_data,
  input  logic [7:0]       line_ctrl,
  input  logic [DIV_W-1:0] baud_int,
  input  logic             bit_end,
  output logic             take,
  output logic             txd,
  output logic             busy
);
  tx_state_e  st;
  frame_cfg_t cfg_q, cfg_n;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic       par_q, par_n;
  logic       txd_q;
  logic [7:0] data_mask;
  logic       configured;
  logic       frame_done;

  assign configured = |baud_int;
  assign frame_done = (st == ST_STOP) && bit_end && (cnt == 4'd0);
  assign take       = hold_full && configured && ((st == ST_IDLE) || frame_done);
  assign busy       = (st != ST_IDLE);
  assign txd        = txd_q;

  always_comb begin
    cfg_n     = decode_lc(line_ctrl);
    data_mask = 8'hFF >> (4'd8 - cfg_n.nbits);
    par_n     = ^(hold_data & data_mask);
    if (!cfg_n.par_even) par_n = !par_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      txd_q <= 1'b1;
      shreg <= '0;
      cnt   <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
    end else if (take) begin
      st    <= ST_START;
      txd_q <= 1'b0;
      shreg <= hold_data;
      cfg_q <= cfg_n;
      par_q <= par_n;
    end else if (bit_end) begin
      unique case (st)
        ST_START: begin
          txd_q <= shreg[0];
          shreg <= shreg >> 1;
          cnt   <= cfg_q.nbits - 4'd1;
          st    <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt == 4'd0) begin
            if (cfg_q.par_en) begin
              txd_q <= par_q;
              st    <= ST_PAR;
            end else begin
              txd_q <= 1'b1;
              cnt   <= {3'b000, cfg_q.two_stop};
              st    <= ST_STOP;
            end
          end else begin
            txd_q <= shreg[0];
            shreg <= shreg >> 1;
            cnt   <= cnt - 4'd1;
          end
        end
        ST_PAR: begin
          txd_q <= 1'b1;
          cnt   <= {3'b000, cfg_q.two_stop};
          st    <= ST_STOP;
        end
        ST_STOP: begin
          if (cnt == 4'd0) st <= ST_IDLE;
          else             cnt <= cnt - 4'd1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> txd_q);

  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd_q && st == ST_START);

  p_no_start_unconfig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !configured && st == ST_IDLE |=> st == ST_IDLE);

  p_level_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bit_end && !take |=> $stable(txd_q));

  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_STOP |-> txd_q);

endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        line_ctrl,
  input  logic [DIV_W-1:0]  baud_int,
  input  logic [FRAC_W-1:0] baud_frac,
  output logic              txd,
  output logic              busy,
  output logic              tx_empty
);
  logic       take;
  logic       hold_full;
  logic [7:0] hold_data;
  logic       bit_end;

  uart_tx_hold #(.DATA_W(8)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  uart_tx_frame #(.DIV_W(DIV_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .line_ctrl (line_ctrl),
    .baud_int  (baud_int),
    .bit_end   (bit_end),
    .take      (take),
    .txd       (txd),
    .busy      (busy)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .OSR(OSR)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (take),
    .run     (busy),
    .div_in  (baud_int),
    .frac_in (baud_frac),
    .bit_end (bit_end)
  );

  assign tx_empty = !busy && !hold_full;

  p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd && in_ready && !busy);

endmodule

// File: tb/uart_tx_frac_bench.sv
`timescale 1ns/1ps
module uart_tx_frac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  line_ctrl = 8'h03;
  logic [15:0] baud_int = 16'd1;
  logic [2:0]  baud_frac = 3'd0;
  logic        txd, busy, tx_empty;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_tx_frac u_uart_tx_frac (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .line_ctrl(line_ctrl), .baud_int(baud_int),
    .baud_frac(baud_frac), .txd(txd), .busy(busy), .tx_empty(tx_empty)
  );

  typedef struct packed {
    logic [7:0]  lc;
    logic [15:0] dv;
    logic [2:0]  fr;
    logic [7:0]  d;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{lc: 8'h03, dv: 16'd1, fr: 3'd0, d: 8'hA5},  // 8 data, no parity, 1 stop
    '{lc: 8'h00, dv: 16'd1, fr: 3'd3, d: 8'h1F},  // 5 data
    '{lc: 8'h2B, dv: 16'd2, fr: 3'd5, d: 8'hC3},  // 8 data, even parity
    '{lc: 8'h26, dv: 16'd1, fr: 3'd7, d: 8'h5A},  // 7 data, odd parity, 2 stop
    '{lc: 8'h2F, dv: 16'd1, fr: 3'd1, d: 8'hFF},  // 8 data, even, 2 stop
    '{lc: 8'h21, dv: 16'd3, fr: 3'd2, d: 8'h6C},  // 6 data, odd parity
    '{lc: 8'h43, dv: 16'd1, fr: 3'd0, d: 8'hA5},  // R9: bit 6 set, same as entry 0
    '{lc: 8'h07, dv: 16'd1, fr: 3'd7, d: 8'h00}   // 8 data, 2 stop
  };

  function automatic int period(input logic [15:0] dv, input logic [2:0] fr);
    return 16 * int'(dv) + int'(fr) + 16;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Compares every clock of one frame with the expected waveform (R1 R2 R3 R4).
  task automatic capture(input logic [7:0] lc, input logic [7:0] d, input int per,
                         input bit immediate, input string req);
    logic [15:0] bits;
    int nb, idx, n, errs, guard, first_t;
    logic p, first_act, first_exp;
    nb = 5 + int'(lc[1:0]);
    bits = '1;
    bits[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bits[1 + i] = d[i];
      p ^= d[i];
    end
    idx = 1 + nb;
    if (lc[5]) begin
      bits[idx] = lc[3] ? p : ~p;
      idx++;
    end
    n = idx + 1 + int'(lc[2]);
    if (immediate) @(negedge clk);
    else begin
      guard = 0;
      do begin
        @(negedge clk);
        guard++;
      end while (txd !== 1'b0 && guard < 5000);
    end
    errs = 0; first_t = -1; first_act = 1'b0; first_exp = 1'b0;
    for (int t = 0; t < n * per; t++) begin
      if (t > 0) @(negedge clk);
      if (t == 0) check(busy === 1'b1 && tx_empty === 1'b0, "R8", "busy/empty during frame",
                        int'({busy, tx_empty}), 2);
      if (txd !== bits[t / per]) begin
        if (errs == 0) begin
          first_t = t; first_act = txd; first_exp = bits[t / per];
        end
        errs++;
      end
    end
    checks++;
    if (errs != 0) begin
      failures++;
      $display("FAIL %s frame data=%02h cycle %0d: actual=%0d expected=%0d (%0d bad cycles)",
               req, d, first_t, first_act, first_exp, errs);
    end
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check(busy === 1'b0 && tx_empty === 1'b1 && txd === 1'b1, req, "idle after frame",
          int'({busy, tx_empty, txd}), 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(txd === 1'b1, "R11", "txd", int'(txd), 1);
    check(busy === 1'b0, "R11", "busy", int'(busy), 0);
    check(tx_empty === 1'b1, "R11", "tx_empty", int'(tx_empty), 1);
    check(in_ready === 1'b1, "R11", "in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R9 across formats and divisors
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      line_ctrl = VECS[v].lc;
      baud_int  = VECS[v].dv;
      baud_frac = VECS[v].fr;
      fork
        send(VECS[v].d);
        capture(VECS[v].lc, VECS[v].d, period(VECS[v].dv, VECS[v].fr), 1'b0, "R1/R2/R3/R4/R9");
      join
      idle_check("R8");
    end

    // R5: divisor zero holds the byte; R6: ready low while held
    @(negedge clk);
    line_ctrl = 8'h03; baud_int = 16'd0; baud_frac = 3'd0;
    send(8'h3C);
    repeat (100) @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0, "R5", "no frame while divisor zero",
          int'({txd, busy}), 2);
    check(tx_empty === 1'b0, "R8", "tx_empty with held byte", int'(tx_empty), 0);
    check(in_ready === 1'b0, "R6", "in_ready while held", int'(in_ready), 0);
    fork
      begin @(negedge clk); baud_int = 16'd1; end
      capture(8'h03, 8'h3C, 32, 1'b0, "R5");
    join
    idle_check("R5");

    // R10: settings changed mid-frame do not alter it
    @(negedge clk);
    line_ctrl = 8'h2B; baud_int = 16'd1; baud_frac = 3'd2;
    fork
      send(8'h96);
      capture(8'h2B, 8'h96, 34, 1'b0, "R10");
      begin
        repeat (60) @(negedge clk);
        line_ctrl = 8'h04; baud_int = 16'd3; baud_frac = 3'd0;
      end
    join
    idle_check("R10");

    // R7/R6: three queued bytes; third is accepted in the hand-over cycle
    @(negedge clk);
    line_ctrl = 8'h03; baud_int = 16'd1; baud_frac = 3'd1;
    fork
      begin send(8'h81); send(8'h42); send(8'hE7); end
      begin
        capture(8'h03, 8'h81, 33, 1'b0, "R7");
        capture(8'h03, 8'h42, 33, 1'b1, "R7");
        capture(8'h03, 8'hE7, 33, 1'b1, "R6/R7");
      end
    join
    idle_check("R7");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule